// File: doc/BRIEF.md
# Synchronous Serial Master Shifter

This block is the master side of a clocked serial link. It generates the transfer clock and moves one 8-bit character out on the data output while it takes one in from the data input. Software writes a character into a transmit holding register. When transmit is enabled, the character is copied into an internal shift register and shifted out. At the same time the incoming bits are collected and then moved into a receive holding register. Control inputs set the idle level and the active edges of the clock, the bit order, an optional inversion of both data lines, when the transmit interrupt fires, and a continuous-receive mode.

The bit rate comes from the system clock. A prescaler divides it by 1, 2, 8 or 32, and an 8-bit divider `n` then sets each half period of the transfer clock to `(n+1)` prescaled ticks. Slave-select lines are plain registered outputs that follow a software-written value.

The controller is a three-state machine:
- **IDLE**: the clock rests at its idle level.
- **PRE**: waits one half period and ends on the leading clock edge.
- **POST**: waits one half period and ends on the trailing clock edge.

Its transitions are:
- IDLE→PRE (*load*): a buffered character is accepted while transmit is enabled.
- PRE→POST (*leading edge*).
- POST→PRE (*next bit*): a trailing edge that is not the last.
- POST→PRE (*reload*): the last trailing edge, with another character already waiting.
- POST→IDLE (*finish*): the last trailing edge, with the transmit buffer empty.

Top module: `sync_serial_master`

## Requirements
- R1: After reset the clock output equals `cpol`, `tx_empty` is 1, and `rx_full`, `overrun`, `tx_irq` and `rx_irq` are 0.
- R2: Every half period of `sclk` lasts `(divider+1)*P` system clocks. P is 1, 2, 8 or 32 for `presc_sel` values 0, 1, 2 and 3.
- R3: A transfer starts only while `tx_en` is 1 and the transmit buffer holds an unsent character. With `tx_en` at 0, a written character waits: `sclk` does not move and `tx_empty` stays 0.
- R4: `sclk` rests at `cpol` between transfers. When `cpha` is 0, the first bit is on `sdo` before the leading edge, input is sampled on leading edges and output changes on trailing edges. When `cpha` is 1, output changes on leading edges and input is sampled on trailing edges.
- R5: When `msb_first` is 1, bit 7 is sent and received first. When it is 0, bit 0 goes first.
- R6: When `invert` is 1, the level on `sdo` is the complement of the data bit, and the level on `sdi` is complemented before it is stored.
- R7: When `txirq_at_end` is 0, `tx_irq` pulses for one cycle when a character moves from the buffer to the shifter, and `tx_empty` is already 1 in that cycle. When `txirq_at_end` is 1, it pulses when the last bit completes, in the same cycle as `rx_irq`.
- R8: At the end of a character, the received data goes to `rx_data`, `rx_full` is set and `rx_irq` pulses. This happens only if both `rx_en` and `tx_en` were 1 when that character was loaded. Otherwise `rx_full` stays 0 and `rx_irq` does not pulse. A pulse on `rx_rd` clears `rx_full`.
- R9: `overrun` is set when the 7th bit of a character is sampled while `rx_full` is still 1. That character then leaves `rx_data` unchanged and raises no `rx_irq`. `overrun` clears while `rx_en` is 0.
- R10: If the buffer is reloaded during a transfer, the next character follows with exactly one half period at the idle level between the last trailing edge and the next leading edge.
- R11: When `cont_rx` is 1, a read of a full receive buffer marks the transmit buffer as full again, so its content is sent once more and another character is received.
- R12: `sel_n` takes the value of `sel_d` one clock later. Its reset value is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| cpol | input | 1 | Idle level of the transfer clock |
| cpha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| msb_first | input | 1 | Bit order select |
| invert | input | 1 | Complement serial data levels |
| txirq_at_end | input | 1 | Transmit interrupt timing select |
| cont_rx | input | 1 | Continuous-receive mode |
| presc_sel | input | 2 | Prescaler select (÷1, ÷2, ÷8, ÷32) |
| divider | input | DIV_W | Half-period divider n |
| tx_wr | input | 1 | Write strobe for the transmit buffer |
| tx_data | input | W | Character to transmit |
| rx_rd | input | 1 | Read strobe for the receive buffer |
| sel_d | input | NSEL | Slave-select value from software |
| sclk | output | 1 | Transfer clock |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| sel_n | output | NSEL | Registered slave-select lines |
| tx_empty | output | 1 | Transmit buffer has no unsent character |
| rx_full | output | 1 | Receive buffer holds an unread character |
| rx_data | output | W | Receive buffer content |
| tx_irq | output | 1 | Transmit interrupt pulse |
| rx_irq | output | 1 | Receive interrupt pulse |
| overrun | output | 1 | Overrun error flag |

## Verification
The exchange is run in all four clock modes, each with both bit orders, and the data byte is varied. This separates a swapped sample edge from a swapped launch edge, and a reversed character from a correct one. Inverted data levels are tried together with a non-zero idle level. Clock timing is measured for two prescaler and divider pairs, which exposes a wrong prescale ratio or a divider that is off by one. Single characters, back-to-back pairs, characters sent while a buffer is held unread, and characters sent while an enable is off each separate the start, reload, overrun and receive-gating decisions.

// File: rtl/ssm_pkg.sv
`timescale 1ns/1ps
package ssm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRE  = 2'd1,
        ST_POST = 2'd2
    } ssm_state_e;

    localparam int PSC_W = 5;

    // Terminal count of the prescaler for each ratio code (÷1, ÷2, ÷8, ÷32).
    function automatic logic [PSC_W-1:0] psc_limit(input logic [1:0] code);
        unique case (code)
            2'd0:    return PSC_W'(0);
            2'd1:    return PSC_W'(1);
            2'd2:    return PSC_W'(7);
            default: return PSC_W'(31);
        endcase
    endfunction
endpackage

// File: rtl/ssm_baud.sv
`timescale 1ns/1ps
module ssm_baud
    import ssm_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [1:0]       presc_sel,
    input  logic [DIV_W-1:0] divider,
    output logic             half_tick
);
    logic [PSC_W-1:0] psc_q;
    logic [DIV_W-1:0] hcnt_q;
    logic             fj_tick;

    assign fj_tick   = (psc_q == psc_limit(presc_sel));
    assign half_tick = run && fj_tick && (hcnt_q == divider);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psc_q  <= '0;
            hcnt_q <= '0;
        end else if (!run) begin
            psc_q  <= '0;
            hcnt_q <= '0;
        end else begin
            psc_q <= fj_tick ? '0 : psc_q + 1'b1;
            if (fj_tick) begin
                hcnt_q <= half_tick ? '0 : hcnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/ssm_shift.sv
`timescale 1ns/1ps
module ssm_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         launch,
    input  logic         sample,
    input  logic         msb_first,
    input  logic         sdi_bit,
    output logic         sdo_bit,
    output logic [W-1:0] rx_nxt
);
    logic [W-1:0] tx_sr;
    logic [W-1:0] src;
    logic [W-1:0] rx_sr;
    logic         sdo_q;

    always_comb begin
        src    = load ? load_data : tx_sr;
        rx_nxt = rx_sr;
        if (sample) begin
            rx_nxt = msb_first ? {rx_sr[W-2:0], sdi_bit} : {sdi_bit, rx_sr[W-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sr <= '0;
            rx_sr <= '0;
            sdo_q <= 1'b0;
        end else begin
            if (launch) begin
                sdo_q <= msb_first ? src[W-1] : src[0];
                tx_sr <= msb_first ? {src[W-2:0], 1'b0} : {1'b0, src[W-1:1]};
            end else if (load) begin
                tx_sr <= load_data;
            end
            rx_sr <= rx_nxt;
        end
    end

    assign sdo_bit = sdo_q;
endmodule

// File: rtl/sync_serial_master.sv
`timescale 1ns/1ps
module sync_serial_master
    import ssm_pkg::*;
#(
    parameter int W     = 8,
    parameter int DIV_W = 8,
    parameter int NSEL  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic             rx_en,
    input  logic             cpol,
    input  logic             cpha,
    input  logic             msb_first,
    input  logic             invert,
    input  logic             txirq_at_end,
    input  logic             cont_rx,
    input  logic [1:0]       presc_sel,
    input  logic [DIV_W-1:0] divider,
    input  logic             tx_wr,
    input  logic [W-1:0]     tx_data,
    input  logic             rx_rd,
    input  logic [NSEL-1:0]  sel_d,
    output logic             sclk,
    output logic             sdo,
    input  logic             sdi,
    output logic [NSEL-1:0]  sel_n,
    output logic             tx_empty,
    output logic             rx_full,
    output logic [W-1:0]     rx_data,
    output logic             tx_irq,
    output logic             rx_irq,
    output logic             overrun
);
    localparam int BIT_W = $clog2(W);

    ssm_state_e       state_q, state_d;
    logic [BIT_W-1:0] bit_q;
    logic [W-1:0]     tx_buf_q, rx_buf_q, rx_nxt;
    logic             tx_full_q, rx_full_q, rx_act_q, ovr_q, ovr_char_q;
    logic             sclk_q, tx_irq_q, rx_irq_q;
    logic [NSEL-1:0]  sel_q;

    logic half_tick, start, last;
    logic load, launch, sample, clk_edge, done;
    logic ovr_hit, deliver, sdo_bit;

    assign start   = tx_en && tx_full_q;
    assign last    = (bit_q == BIT_W'(W-1));
    assign ovr_hit = sample && (bit_q == BIT_W'(W-2)) && rx_act_q && rx_full_q && !rx_rd;
    assign deliver = done && rx_act_q && !ovr_char_q;

    ssm_baud #(.DIV_W(DIV_W)) baud_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (state_q != ST_IDLE),
        .presc_sel (presc_sel),
        .divider   (divider),
        .half_tick (half_tick)
    );

    ssm_shift #(.W(W)) shift_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_data (tx_buf_q),
        .launch    (launch),
        .sample    (sample),
        .msb_first (msb_first),
        .sdi_bit   (sdi ^ invert),
        .sdo_bit   (sdo_bit),
        .rx_nxt    (rx_nxt)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state and per-cycle strobes
    always_comb begin
        state_d  = state_q;
        load     = 1'b0;
        launch   = 1'b0;
        sample   = 1'b0;
        clk_edge = 1'b0;
        done     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    load    = 1'b1;
                    launch  = !cpha;
                    state_d = ST_PRE;
                end
            end
            ST_PRE: begin
                if (half_tick) begin
                    clk_edge = 1'b1;
                    sample   = !cpha;
                    launch   = cpha;
                    state_d  = ST_POST;
                end
            end
            ST_POST: begin
                if (half_tick) begin
                    clk_edge = 1'b1;
                    sample   = cpha;
                    if (last) begin
                        done = 1'b1;
                        if (start) begin
                            load    = 1'b1;
                            launch  = !cpha;
                            state_d = ST_PRE;
                        end else begin
                            state_d = ST_IDLE;
                        end
                    end else begin
                        launch  = !cpha;
                        state_d = ST_PRE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Registered outputs, buffers and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q      <= '0;
            tx_buf_q   <= '0;
            rx_buf_q   <= '0;
            tx_full_q  <= 1'b0;
            rx_full_q  <= 1'b0;
            rx_act_q   <= 1'b0;
            ovr_q      <= 1'b0;
            ovr_char_q <= 1'b0;
            sclk_q     <= 1'b0;
            tx_irq_q   <= 1'b0;
            rx_irq_q   <= 1'b0;
            sel_q      <= '1;
        end else begin
            sel_q    <= sel_d;
            sclk_q   <= sclk_q ^ clk_edge;
            tx_irq_q <= (load && !txirq_at_end) || (done && txirq_at_end);
            rx_irq_q <= deliver;

            if (load) begin
                bit_q      <= '0;
                rx_act_q   <= rx_en && tx_en;
                ovr_char_q <= 1'b0;
            end else begin
                if (clk_edge && state_q == ST_POST) bit_q <= bit_q + 1'b1;
                if (ovr_hit) ovr_char_q <= 1'b1;
            end

            if (tx_wr) tx_buf_q <= tx_data;
            if (tx_wr || (rx_rd && rx_full_q && cont_rx)) tx_full_q <= 1'b1;
            else if (load)                                tx_full_q <= 1'b0;

            if (deliver) begin
                rx_buf_q  <= rx_nxt;
                rx_full_q <= 1'b1;
            end else if (rx_rd) begin
                rx_full_q <= 1'b0;
            end

            if (!rx_en)       ovr_q <= 1'b0;
            else if (ovr_hit) ovr_q <= 1'b1;
        end
    end

    assign sclk     = sclk_q ^ cpol;
    assign sdo      = sdo_bit ^ invert;
    assign sel_n    = sel_q;
    assign tx_empty = !tx_full_q;
    assign rx_full  = rx_full_q;
    assign rx_data  = rx_buf_q;
    assign tx_irq   = tx_irq_q;
    assign rx_irq   = rx_irq_q;
    assign overrun  = ovr_q;
endmodule

// File: rtl/ssm_checker.sv
`timescale 1ns/1ps
module ssm_checker
    import ssm_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cpol,
    input logic       tx_en,
    input logic       sclk,
    input logic       rx_full,
    input logic       rx_irq,
    input logic       tx_irq,
    input logic       overrun,
    input ssm_state_e state_q
);
    p_idle_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (sclk == cpol));

    p_no_start_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !tx_en) |=> (state_q == ST_IDLE));

    p_sclk_only_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(cpol) && !$stable(sclk)) |-> ($past(state_q) != ST_IDLE));

    p_txirq_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |=> !tx_irq);

    p_rxirq_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> rx_full);

    p_ovr_needs_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(rx_full));
endmodule

bind sync_serial_master ssm_checker chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .cpol    (cpol),
    .tx_en   (tx_en),
    .sclk    (sclk),
    .rx_full (rx_full),
    .rx_irq  (rx_irq),
    .tx_irq  (tx_irq),
    .overrun (overrun),
    .state_q (state_q)
);

// File: tb/sync_serial_master_tb_top.sv
`timescale 1ns/1ps
module sync_serial_master_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b1, rx_en = 1'b1, cpol = 1'b0, cpha = 1'b0;
    logic       msb_first = 1'b0, invert = 1'b0, txirq_at_end = 1'b0, cont_rx = 1'b0;
    logic [1:0] presc_sel = 2'd0;
    logic [7:0] divider = 8'd1;
    logic       tx_wr = 1'b0, rx_rd = 1'b0, sdi = 1'b0;
    logic [7:0] tx_data = 8'd0;
    logic [3:0] sel_d = 4'hF;
    logic       sclk, sdo, tx_empty, rx_full, tx_irq, rx_irq, overrun;
    logic [3:0] sel_n;
    logic [7:0] rx_data;

    always #5 clk = ~clk;

    sync_serial_master dut_i (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en), .cpol(cpol), .cpha(cpha),
        .msb_first(msb_first), .invert(invert), .txirq_at_end(txirq_at_end), .cont_rx(cont_rx),
        .presc_sel(presc_sel), .divider(divider), .tx_wr(tx_wr), .tx_data(tx_data),
        .rx_rd(rx_rd), .sel_d(sel_d), .sclk(sclk), .sdo(sdo), .sdi(sdi), .sel_n(sel_n),
        .tx_empty(tx_empty), .rx_full(rx_full), .rx_data(rx_data), .tx_irq(tx_irq),
        .rx_irq(rx_irq), .overrun(overrun)
    );

    int         n_chk = 0, n_fail = 0;
    string      cur_req = "R1";
    int         halfp = 2;
    logic       slave_on = 1'b0;
    logic [7:0] s_tx_q[$];
    logic [7:0] exp_s[$];
    logic [7:0] exp_m[$];
    time        edge_t[$];
    int         s_pos = 0, s_rx_cnt = 0;
    logic [7:0] s_rx_sr = 8'd0;
    int         rxirq_cnt = 0, txirq_cnt = 0;
    logic       txirq_empty = 1'b0, txirq_with_rx = 1'b0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic sbit(input logic [7:0] v, input int p);
        return msb_first ? v[7-p] : v[p];
    endfunction

    // Slave model: drives sdi and collects sdo on the edges of the selected mode
    logic lead_e, b_e;
    always @(sclk) begin
        if (slave_on) begin
            lead_e = (sclk !== cpol);
            edge_t.push_back($time);
            #1;
            if (lead_e ^ cpha) begin
                b_e = sdo ^ invert;
                s_rx_sr = msb_first ? {s_rx_sr[6:0], b_e} : {b_e, s_rx_sr[7:1]};
                s_rx_cnt++;
                if (s_rx_cnt == 8) begin
                    s_rx_cnt = 0;
                    if (exp_s.size() == 0) check({cur_req, " unexpected slave char"}, s_rx_sr, 32'hFFFF);
                    else check({cur_req, " slave rx"}, s_rx_sr, exp_s.pop_front());
                end
            end
            if (!lead_e) begin
                s_pos++;
                if (s_pos == 8) begin
                    s_pos = 0;
                    if (s_tx_q.size() > 0) void'(s_tx_q.pop_front());
                end
            end
            if (!(lead_e ^ cpha)) sdi = (s_tx_q.size() > 0 ? sbit(s_tx_q[0], s_pos) : 1'b0) ^ invert;
        end
    end

    // Monitor: scoreboard for received characters and interrupt observation
    always @(negedge clk) begin
        if (rst_n && rx_irq) begin
            rxirq_cnt++;
            if (exp_m.size() == 0) check({cur_req, " unexpected rx_irq"}, rx_data, 32'hFFFF);
            else check({cur_req, " master rx"}, rx_data, exp_m.pop_front());
        end
        if (rst_n && tx_irq) begin
            txirq_cnt++;
            txirq_empty   = tx_empty;
            txirq_with_rx = rx_irq;
        end
    end

    task automatic setup(input logic c_pol, input logic c_pha, input logic c_msb, input logic c_inv,
                         input logic [1:0] ps, input logic [7:0] dv);
        int ratio;
        slave_on = 1'b0;
        rst_n = 1'b0;
        cpol = c_pol; cpha = c_pha; msb_first = c_msb; invert = c_inv;
        presc_sel = ps; divider = dv;
        tx_en = 1'b1; rx_en = 1'b1; txirq_at_end = 1'b0; cont_rx = 1'b0;
        s_tx_q.delete(); exp_s.delete(); exp_m.delete(); edge_t.delete();
        s_pos = 0; s_rx_cnt = 0; sdi = 1'b0;
        ratio = (ps == 2'd0) ? 1 : (ps == 2'd1) ? 2 : (ps == 2'd2) ? 8 : 32;
        halfp = (int'(dv) + 1) * ratio;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        slave_on = 1'b1;
    endtask

    task automatic xfer(input logic [7:0] m, input logic [7:0] s, input bit want_rx);
        if (s_tx_q.size() == 0) sdi = sbit(s, 0) ^ invert;
        s_tx_q.push_back(s);
        exp_s.push_back(m);
        if (want_rx) exp_m.push_back(s);
        @(negedge clk); tx_wr = 1'b1; tx_data = m;
        @(negedge clk); tx_wr = 1'b0;
    endtask

    task automatic wait_done();
        wait (tx_empty);
        repeat (17 * halfp + 4) @(negedge clk);
    endtask

    task automatic rd();
        @(negedge clk); rx_rd = 1'b1;
        @(negedge clk); rx_rd = 1'b0;
    endtask

    initial begin
        int c0;
        // R1 reset state
        setup(1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'd1);
        cur_req = "R1";
        check("R1 sclk idle", sclk, 0);
        check("R1 tx_empty", tx_empty, 1);
        check("R1 rx_full", rx_full, 0);
        check("R1 overrun", overrun, 0);
        check("R1 irqs", {tx_irq, rx_irq}, 0);

        // R4/R5: all clock modes, both bit orders
        for (int m = 0; m < 4; m++) begin
            for (int b = 0; b < 2; b++) begin
                setup(m[1], m[0], b[0], 1'b0, 2'd0, 8'd1);
                cur_req = "R4/R5";
                xfer(8'(8'h3A + m * 16 + b), 8'(8'hC5 ^ (m * 8 + b)), 1'b1);
                wait_done();
                check("R4 idle level", sclk, m[1]);
                check("R8 rx_full set", rx_full, 1);
                rd();
                check("R8 rx_full cleared", rx_full, 0);
            end
        end

        // R6 inversion
        setup(1'b1, 1'b0, 1'b1, 1'b1, 2'd0, 8'd0);
        cur_req = "R6";
        xfer(8'h96, 8'h2D, 1'b1);
        wait_done();
        rd();

        // R2 timing
        setup(1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 8'd3);
        cur_req = "R2";
        xfer(8'h81, 8'h7E, 1'b1);
        wait_done();
        check("R2 edge count", edge_t.size(), 16);
        check("R2 half period div2 n3", 32'(edge_t[1] - edge_t[0]), 80);
        setup(1'b1, 1'b1, 1'b1, 1'b0, 2'd3, 8'd0);
        xfer(8'h0F, 8'hF0, 1'b1);
        wait_done();
        check("R2 half period div32 n0", 32'(edge_t[2] - edge_t[1]), 320);

        // R3 transmit enable gating
        setup(1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 8'd1);
        cur_req = "R3";
        tx_en = 1'b0;
        xfer(8'h55, 8'hAA, 1'b1);
        repeat (100) @(negedge clk);
        check("R3 no clock when disabled", edge_t.size(), 0);
        check("R3 buffer held", tx_empty, 0);
        tx_en = 1'b1;
        wait_done();
        rd();

        // R7 transmit interrupt timing
        setup(1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 8'd1);
        cur_req = "R7";
        c0 = txirq_cnt;
        xfer(8'hE1, 8'h1E, 1'b1);
        wait_done();
        check("R7 one irq at load", txirq_cnt, c0 + 1);
        check("R7 buffer empty at irq", txirq_empty, 1);
        check("R7 not with rx_irq", txirq_with_rx, 0);
        rd();
        txirq_at_end = 1'b1;
        xfer(8'h42, 8'h24, 1'b1);
        wait_done();
        check("R7 one irq at end", txirq_cnt, c0 + 2);
        check("R7 irq with rx_irq", txirq_with_rx, 1);
        rd();

        // R8 receive disabled
        setup(1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'd1);
        cur_req = "R8";
        rx_en = 1'b0;
        c0 = rxirq_cnt;
        xfer(8'h99, 8'h66, 1'b0);
        wait_done();
        check("R8 no rx_full when disabled", rx_full, 0);
        check("R8 no rx_irq when disabled", rxirq_cnt, c0);

        // R9 overrun
        setup(1'b0, 1'b1, 1'b1, 1'b0, 2'd0, 8'd1);
        cur_req = "R9";
        c0 = rxirq_cnt;
        xfer(8'h11, 8'h22, 1'b1);
        wait_done();
        xfer(8'h33, 8'h44, 1'b0);
        wait_done();
        check("R9 overrun set", overrun, 1);
        check("R9 buffer kept", rx_data, 8'h22);
        check("R9 single rx_irq", rxirq_cnt, c0 + 1);
        rx_en = 1'b0;
        repeat (2) @(negedge clk);
        check("R9 overrun cleared", overrun, 0);

        // R10 back-to-back
        setup(1'b0, 1'b1, 1'b1, 1'b0, 2'd0, 8'd2);
        cur_req = "R10";
        rx_en = 1'b0;
        xfer(8'hA7, 8'h3C, 1'b0);
        xfer(8'h5E, 8'hC3, 1'b0);
        wait_done();
        check("R10 edge count", edge_t.size(), 32);
        check("R10 gap between chars", 32'(edge_t[16] - edge_t[15]), 30);
        check("R10 half period", 32'(edge_t[1] - edge_t[0]), 30);

        // R11 continuous receive
        setup(1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'd1);
        cur_req = "R11";
        cont_rx = 1'b1;
        xfer(8'h5A, 8'h66, 1'b1);
        wait_done();
        sdi = sbit(8'h77, 0) ^ invert;
        s_tx_q.push_back(8'h77);
        exp_s.push_back(8'h5A);
        exp_m.push_back(8'h77);
        rd();
        wait_done();
        check("R11 re-armed receive", rx_full, 1);
        check("R11 new data", rx_data, 8'h77);

        // R12 select lines
        cur_req = "R12";
        @(negedge clk); sel_d = 4'hA;
        @(negedge clk);
        check("R12 select follows", sel_n, 4'hA);

        check("R8 scoreboard drained", exp_m.size() + exp_s.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog %s actual=timeout expected=done", cur_req);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule